// File: doc/BRIEF.md
# Wide Register Bus Collector

This block is the bridge between a narrow host bus of 32-bit or 64-bit accesses and a device whose normal control registers are 128 bits wide and whose internal SRAM holds 64-bit entries. The host cannot write a full wide register in one access. It sends the register in pieces. The block collects those pieces in a staging buffer and updates the target register in a single cycle, only when the final piece arrives. A wide register therefore never holds a half-written value.

Reads work the other way round. Reading the lowest dword of a wide register captures the whole 128-bit value into a read shadow. The later piece reads are served from that shadow, so the host sees one consistent snapshot even if the register changes between its accesses. Three narrow doorbell-style registers (event-queue read pointer, receive descriptor update, transmit descriptor update) take standalone 32-bit writes at once. Such a write may land in the middle of a wide collection without disturbing it. The whole map repeats once per page of 0x2000 bytes. Illegal piece sequences raise a sticky error flag.

Top module: `wide_reg_collector`

## Requirements
- R1: After reset every wide register, doorbell register and SRAM entry reads as zero, `rsp_valid` is 0 and `err_flag` is 0.
- R2: Address map inside a page: wide register i sits at 0x000 + 16·i, with its dwords at +0, +4, +8 and +12. Doorbell k (0 = event-queue read pointer, 1 = receive update, 2 = transmit update) sits at 0x800 + 16·k. SRAM entry j sits at 0x1000 + 8·j, with its high dword at +4. Page p adds p·0x2000.
- R3: Writes to dwords 0, 1 and 2 of a wide register only fill the staging buffer. Until the commit, the register keeps its old value.
- R4: A write to dword 3 commits all 128 staged bits at once. So does a 64-bit write at +8, which carries dwords 2 and 3. A 64-bit write at +0 carries dwords 0 and 1.
- R5: A dword-3 write is dropped and sets `err_flag` unless dwords 0, 1 and 2 of the same register were all staged since the last commit or drop. Every dword-3 write ends the collection.
- R6: A dword-1, dword-2 or dword-3 write whose register differs from the one addressed by the staged dword 0 is discarded and sets `err_flag`.
- R7: A read of dword 0 (32-bit or 64-bit) returns live data and loads the register's full value into the read shadow. Reads of dwords 1 to 3 return shadow contents.
- R8: A doorbell write takes effect at once. It leaves an open wide collection intact, so that collection still commits correctly.
- R9: A 32-bit write to an SRAM entry's low dword is staged. The 32-bit write to its high dword commits both halves. A 64-bit write commits at once. A high-dword write with no matching staged low dword is dropped and sets `err_flag`. SRAM reads return live data.
- R10: Byte strobes apply at commit time. Bytes whose strobe bit was 0 keep the target's previous value. A 32-bit access uses `req_wdata[31:0]` and `req_wstrb[3:0]`.
- R11: `req_size` 0 means 32 bits and 1 means 64 bits. A read accepted on one edge returns `rsp_valid`=1 with its data after that edge. A 32-bit read returns zero in `rsp_rdata[63:32]`. Writes give no response.
- R12: Unmapped addresses, misaligned 64-bit accesses and any 64-bit access to a doorbell read as zero. Writes to them are ignored without error.
- R13: `err_flag` stays set until `err_clr` is sampled high. A new error on the same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = 32-bit, 1 = 64-bit |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Write data |
| req_wstrb | input | 8 | Byte strobes |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| err_clr | input | 1 | Clears the sticky error flag |
| err_flag | output | 1 | Sticky sequence error |

## Verification
Every request is accepted on the edge where `req_valid` is high. Read data and `rsp_valid` are registered on that same edge. The bench drives each request at a falling edge and samples the response at the next falling edge, one half cycle after acceptance. A committed write changes state on its accepting edge, so the read issued next returns the new value. The bench checks uncommitted state through reads that follow the staging writes and come before the commit. `err_flag` rises on the edge that accepts the offending piece, and the bench reads it at the falling edge that follows.

// File: rtl/wrc_pkg.sv
`timescale 1ns/1ps
package wrc_pkg;
  localparam int PAGE_SHIFT = 13;
  localparam int WIDE_BASE  = 'h000;
  localparam int DB_BASE    = 'h800;
  localparam int SRAM_BASE  = 'h1000;
  localparam int STRIDE     = 16;
  localparam int NUM_DB     = 3;
  localparam int SRAM_BYTES = 8;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_WIDE = 2'd1,
    RG_DB   = 2'd2,
    RG_SRAM = 2'd3
  } region_e;
endpackage

// File: rtl/wrc_decode.sv
`timescale 1ns/1ps
module wrc_decode
  import wrc_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int PAGES      = 2,
  parameter int NUM_WIDE   = 4,
  parameter int SRAM_DEPTH = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is64,
  output region_e           region,
  output logic [((PAGES*NUM_WIDE)>1 ? $clog2(PAGES*NUM_WIDE) : 1)-1:0] wide_idx,
  output logic [((PAGES*NUM_DB)>1 ? $clog2(PAGES*NUM_DB) : 1)-1:0]     db_idx,
  output logic [((PAGES*SRAM_DEPTH)>1 ? $clog2(PAGES*SRAM_DEPTH) : 1)-1:0] sram_idx,
  output logic [1:0]        piece
);
  localparam int PG_W = ADDR_W - PAGE_SHIFT;
  localparam int WI_W = (PAGES*NUM_WIDE) > 1 ? $clog2(PAGES*NUM_WIDE) : 1;
  localparam int DI_W = (PAGES*NUM_DB) > 1 ? $clog2(PAGES*NUM_DB) : 1;
  localparam int SI_W = (PAGES*SRAM_DEPTH) > 1 ? $clog2(PAGES*SRAM_DEPTH) : 1;

  logic [PAGE_SHIFT-1:0] off;
  logic [PG_W-1:0]       page;
  int                    off_i;
  int                    page_i;

  assign off    = addr[PAGE_SHIFT-1:0];
  assign page   = addr[ADDR_W-1:PAGE_SHIFT];
  assign off_i  = int'(off);
  assign page_i = int'(page);

  always_comb begin
    region   = RG_NONE;
    wide_idx = '0;
    db_idx   = '0;
    sram_idx = '0;
    piece    = 2'd0;
    if (page_i < PAGES && addr[1:0] == 2'b00) begin
      if (off_i >= WIDE_BASE && off_i < WIDE_BASE + NUM_WIDE*STRIDE) begin
        if (!is64 || !addr[2]) begin
          region   = RG_WIDE;
          wide_idx = WI_W'(page_i*NUM_WIDE + (off_i - WIDE_BASE)/STRIDE);
          piece    = off[3:2];
        end
      end else if (off_i >= DB_BASE && off_i < DB_BASE + NUM_DB*STRIDE) begin
        if (!is64 && off[3:2] == 2'b00) begin
          region = RG_DB;
          db_idx = DI_W'(page_i*NUM_DB + (off_i - DB_BASE)/STRIDE);
        end
      end else if (off_i >= SRAM_BASE && off_i < SRAM_BASE + SRAM_DEPTH*SRAM_BYTES) begin
        if (!is64 || !addr[2]) begin
          region   = RG_SRAM;
          sram_idx = SI_W'(page_i*SRAM_DEPTH + (off_i - SRAM_BASE)/SRAM_BYTES);
          piece    = {1'b0, off[2]};
        end
      end
    end
  end
endmodule

// File: rtl/wrc_wide_bank.sv
`timescale 1ns/1ps
module wrc_wide_bank #(
  parameter int PAGES    = 2,
  parameter int NUM_WIDE = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic        is64,
  input  logic [((PAGES*NUM_WIDE)>1 ? $clog2(PAGES*NUM_WIDE) : 1)-1:0] idx,
  input  logic [1:0]  piece,
  input  logic [63:0] wdata,
  input  logic [7:0]  wstrb,
  output logic [63:0] rdata,
  output logic        err_pulse
);
  localparam int WIDE_N = PAGES*NUM_WIDE;
  localparam int WI_W   = WIDE_N > 1 ? $clog2(WIDE_N) : 1;

  logic [127:0]    regs [WIDE_N];
  logic [127:0]    shadow;
  logic [127:0]    stage_data;
  logic [15:0]     stage_be;
  logic [2:0]      stage_vld;
  logic [WI_W-1:0] stage_idx;

  logic [3:0]   carry;
  logic [127:0] pdata, lane_m, merged_data, byte_m, cur, next_val;
  logic [15:0]  pbe, lane_be, merged_be;
  logic [2:0]   merged_vld;
  logic         match, is_first, is_last, commit_ok;

  always_comb begin
    carry      = (is64 ? 4'b0011 : 4'b0001) << piece;
    pdata      = {64'd0, (is64 ? wdata : {32'd0, wdata[31:0]})} << {piece, 5'd0};
    pbe        = {8'd0, (is64 ? wstrb : {4'd0, wstrb[3:0]})} << {piece, 2'd0};
    for (int i = 0; i < 4; i++) begin
      lane_m[i*32 +: 32] = {32{carry[i]}};
      lane_be[i*4 +: 4]  = {4{carry[i]}};
    end
    merged_data = (stage_data & ~lane_m) | pdata;
    merged_be   = (stage_be & ~lane_be) | pbe;
    merged_vld  = stage_vld | carry[2:0];
    for (int b = 0; b < 16; b++) byte_m[b*8 +: 8] = {8{merged_be[b]}};
    cur        = regs[idx];
    next_val   = (cur & ~byte_m) | (merged_data & byte_m);
    is_first   = carry[0];
    is_last    = carry[3];
    match      = stage_vld[0] && (stage_idx == idx);
    commit_ok  = is_last && match && (&merged_vld);
    err_pulse  = wr_en && !is_first && (is_last ? !commit_ok : !match);
    rdata      = 64'((piece == 2'd0 ? cur : shadow) >> {piece, 5'd0});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WIDE_N; i++) regs[i] <= '0;
      shadow     <= '0;
      stage_data <= '0;
      stage_be   <= '0;
      stage_vld  <= '0;
      stage_idx  <= '0;
    end else begin
      if (wr_en) begin
        if (is_first) begin
          stage_idx  <= idx;
          stage_data <= pdata;
          stage_be   <= pbe;
          stage_vld  <= carry[2:0];
        end else if (is_last) begin
          stage_vld <= '0;
          if (commit_ok) regs[idx] <= next_val;
        end else if (match) begin
          stage_data <= merged_data;
          stage_be   <= merged_be;
          stage_vld  <= merged_vld;
        end
      end
      if (rd_en && piece == 2'd0) shadow <= cur;
    end
  end
endmodule

// File: rtl/wrc_sram_bank.sv
`timescale 1ns/1ps
module wrc_sram_bank #(
  parameter int PAGES      = 2,
  parameter int SRAM_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        is64,
  input  logic [((PAGES*SRAM_DEPTH)>1 ? $clog2(PAGES*SRAM_DEPTH) : 1)-1:0] idx,
  input  logic        hi,
  input  logic [63:0] wdata,
  input  logic [7:0]  wstrb,
  output logic [63:0] rdata,
  output logic        err_pulse
);
  localparam int SRAM_N = PAGES*SRAM_DEPTH;
  localparam int SI_W   = SRAM_N > 1 ? $clog2(SRAM_N) : 1;

  logic [63:0]     mem [SRAM_N];
  logic [31:0]     lo_data;
  logic [3:0]      lo_be;
  logic            lo_vld;
  logic [SI_W-1:0] lo_idx;

  logic [63:0] cur, wval, bmask;
  logic [7:0]  wbe;
  logic        pair_ok;

  always_comb begin
    cur     = mem[idx];
    pair_ok = lo_vld && (lo_idx == idx);
    wval    = is64 ? wdata : {wdata[31:0], lo_data};
    wbe     = is64 ? wstrb : {wstrb[3:0], lo_be};
    for (int b = 0; b < 8; b++) bmask[b*8 +: 8] = {8{wbe[b]}};
    err_pulse = wr_en && !is64 && hi && !pair_ok;
    rdata     = hi ? {32'd0, cur[63:32]} : cur;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SRAM_N; i++) mem[i] <= '0;
      lo_data <= '0;
      lo_be   <= '0;
      lo_vld  <= 1'b0;
      lo_idx  <= '0;
    end else if (wr_en) begin
      if (is64) begin
        mem[idx] <= (cur & ~bmask) | (wval & bmask);
      end else if (!hi) begin
        lo_data <= wdata[31:0];
        lo_be   <= wstrb[3:0];
        lo_idx  <= idx;
        lo_vld  <= 1'b1;
      end else begin
        lo_vld <= 1'b0;
        if (pair_ok) mem[idx] <= (cur & ~bmask) | (wval & bmask);
      end
    end
  end
endmodule

// File: rtl/wrc_db_bank.sv
`timescale 1ns/1ps
module wrc_db_bank
  import wrc_pkg::*;
#(
  parameter int PAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [((PAGES*NUM_DB)>1 ? $clog2(PAGES*NUM_DB) : 1)-1:0] idx,
  input  logic [31:0] wdata,
  input  logic [3:0]  wstrb,
  output logic [63:0] rdata
);
  localparam int DB_N = PAGES*NUM_DB;

  logic [31:0] regs [DB_N];
  logic [31:0] bmask;

  always_comb begin
    for (int b = 0; b < 4; b++) bmask[b*8 +: 8] = {8{wstrb[b]}};
    rdata = {32'd0, regs[idx]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DB_N; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[idx] <= (regs[idx] & ~bmask) | (wdata & bmask);
    end
  end
endmodule

// File: rtl/wide_reg_collector.sv
`timescale 1ns/1ps
module wide_reg_collector
  import wrc_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int PAGES      = 2,
  parameter int NUM_WIDE   = 4,
  parameter int SRAM_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  input  logic [7:0]        req_wstrb,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  input  logic              err_clr,
  output logic              err_flag
);
  localparam int WI_W = (PAGES*NUM_WIDE) > 1 ? $clog2(PAGES*NUM_WIDE) : 1;
  localparam int DI_W = (PAGES*NUM_DB) > 1 ? $clog2(PAGES*NUM_DB) : 1;
  localparam int SI_W = (PAGES*SRAM_DEPTH) > 1 ? $clog2(PAGES*SRAM_DEPTH) : 1;

  region_e         region;
  logic [WI_W-1:0] wide_idx;
  logic [DI_W-1:0] db_idx;
  logic [SI_W-1:0] sram_idx;
  logic [1:0]      piece;
  logic [63:0]     wide_rd, db_rd, sram_rd, sel_rd;
  logic            wide_err, sram_err;
  logic            do_wr, do_rd;

  assign req_ready = 1'b1;
  assign do_wr     = req_valid && req_write;
  assign do_rd     = req_valid && !req_write;

  wrc_decode #(
    .ADDR_W(ADDR_W), .PAGES(PAGES), .NUM_WIDE(NUM_WIDE), .SRAM_DEPTH(SRAM_DEPTH)
  ) i_decode (
    .addr(req_addr), .is64(req_size), .region(region),
    .wide_idx(wide_idx), .db_idx(db_idx), .sram_idx(sram_idx), .piece(piece)
  );

  wrc_wide_bank #(.PAGES(PAGES), .NUM_WIDE(NUM_WIDE)) i_wide (
    .clk(clk), .rst(rst),
    .wr_en(do_wr && region == RG_WIDE), .rd_en(do_rd && region == RG_WIDE),
    .is64(req_size), .idx(wide_idx), .piece(piece),
    .wdata(req_wdata), .wstrb(req_wstrb), .rdata(wide_rd), .err_pulse(wide_err)
  );

  wrc_db_bank #(.PAGES(PAGES)) i_db (
    .clk(clk), .rst(rst), .wr_en(do_wr && region == RG_DB), .idx(db_idx),
    .wdata(req_wdata[31:0]), .wstrb(req_wstrb[3:0]), .rdata(db_rd)
  );

  wrc_sram_bank #(.PAGES(PAGES), .SRAM_DEPTH(SRAM_DEPTH)) i_sram (
    .clk(clk), .rst(rst), .wr_en(do_wr && region == RG_SRAM),
    .is64(req_size), .idx(sram_idx), .hi(piece[0]),
    .wdata(req_wdata), .wstrb(req_wstrb), .rdata(sram_rd), .err_pulse(sram_err)
  );

  always_comb begin
    case (region)
      RG_WIDE: sel_rd = wide_rd;
      RG_DB:   sel_rd = db_rd;
      RG_SRAM: sel_rd = sram_rd;
      default: sel_rd = '0;
    endcase
    if (!req_size) sel_rd[63:32] = 32'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      err_flag  <= 1'b0;
    end else begin
      rsp_valid <= do_rd;
      if (do_rd) rsp_rdata <= sel_rd;
      if (wide_err || sram_err) err_flag <= 1'b1;
      else if (err_clr)         err_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/wrc_checker.sv
`timescale 1ns/1ps
module wrc_checker (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_write,
  input logic        req_size,
  input logic        rsp_valid,
  input logic [63:0] rsp_rdata,
  input logic        err_clr,
  input logic        err_flag
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !err_flag));

  // R11
  read_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid);

  // R11
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R11
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !req_size) |=> (rsp_rdata[63:32] == 32'd0));

  // R13
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clr) |=> err_flag);

  // R5
  err_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!err_flag && !(req_valid && req_write)) |=> !err_flag);
endmodule

bind wide_reg_collector wrc_checker i_wrc_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_size(req_size), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .err_clr(err_clr), .err_flag(err_flag)
);

// File: tb/test_wide_reg_collector.sv
`timescale 1ns/1ps
module test_wide_reg_collector;
  localparam int ADDR_W = 14;
  localparam int PAGES  = 2;
  localparam int NW     = 4;
  localparam int SD     = 8;
  localparam int PG     = 'h2000;
  localparam int DBB    = 'h800;
  localparam int SRB    = 'h1000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0, req_write = 1'b0, req_size = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [63:0]       req_wdata = '0;
  logic [7:0]        req_wstrb = '0;
  logic              rsp_valid;
  logic [63:0]       rsp_rdata;
  logic              err_clr = 1'b0;
  logic              err_flag;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic last_rv;

  logic [127:0] wm [PAGES*NW];
  logic [31:0]  dm [PAGES*3];
  logic [63:0]  sm [PAGES*SD];

  always #2.5 clk = ~clk;

  wide_reg_collector #(.ADDR_W(ADDR_W), .PAGES(PAGES), .NUM_WIDE(NW), .SRAM_DEPTH(SD)) i_wide_reg_collector (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_wstrb(req_wstrb), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .err_clr(err_clr), .err_flag(err_flag)
  );

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic sz, input int addr,
                      input logic [63:0] d, input logic [7:0] s, output logic [63:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz;
    req_addr = ADDR_W'(addr); req_wdata = d; req_wstrb = s;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    last_rv = rsp_valid;
    rd = rsp_rdata;
  endtask

  task automatic wr32(input int a, input logic [31:0] d, input logic [3:0] s = 4'hF);
    logic [63:0] x;
    xfer(1'b1, 1'b0, a, {32'd0, d}, {4'd0, s}, x);
  endtask

  task automatic wr64(input int a, input logic [63:0] d, input logic [7:0] s = 8'hFF);
    logic [63:0] x;
    xfer(1'b1, 1'b1, a, d, s, x);
  endtask

  task automatic rd32(input int a, output logic [63:0] r);
    xfer(1'b0, 1'b0, a, 64'd0, 8'd0, r);
  endtask

  task automatic rd64(input int a, output logic [63:0] r);
    xfer(1'b0, 1'b1, a, 64'd0, 8'd0, r);
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n, input logic [3:0] s);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = s[b] ? n[b*8 +: 8] : o[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] pat(input int a);
    return 32'(a) * 32'h0100_0193 ^ 32'hA5C3_0F00;
  endfunction

  function automatic int wa(input int p, input int i, input int d);
    return p*PG + i*16 + d*4;
  endfunction

  task automatic wide_full(input int p, input int i, input logic [127:0] v, input bit q);
    if (q) begin
      wr64(wa(p,i,0), v[63:0]);
      wr64(wa(p,i,2), v[127:64]);
    end else begin
      for (int d = 0; d < 4; d++) wr32(wa(p,i,d), v[d*32 +: 32]);
    end
  endtask

  task automatic wide_check(input string req, input int p, input int i);
    logic [63:0] r;
    for (int d = 0; d < 4; d++) begin
      rd32(wa(p,i,d), r);
      chk(req, {64'd0, r}, {96'd0, wm[p*NW+i][d*32 +: 32]});
    end
    rd64(wa(p,i,0), r);
    chk(req, {64'd0, r}, {64'd0, wm[p*NW+i][63:0]});
    rd64(wa(p,i,2), r);
    chk(req, {64'd0, r}, {64'd0, wm[p*NW+i][127:64]});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0]  r;
    logic [127:0] v, snap;
    for (int i = 0; i < PAGES*NW; i++) wm[i] = '0;
    for (int i = 0; i < PAGES*3;  i++) dm[i] = '0;
    for (int i = 0; i < PAGES*SD; i++) sm[i] = '0;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 rsp_valid", {127'd0, rsp_valid}, 128'd0);
    chk("R1 err_flag",  {127'd0, err_flag},  128'd0);
    for (int p = 0; p < PAGES; p++) begin
      for (int i = 0; i < NW; i++) wide_check("R1 wide zero", p, i);
      for (int k = 0; k < 3; k++) begin
        rd32(p*PG + DBB + k*16, r);
        chk("R1 doorbell zero", {64'd0, r}, 128'd0);
      end
      for (int j = 0; j < SD; j++) begin
        rd64(p*PG + SRB + j*8, r);
        chk("R1 sram zero", {64'd0, r}, 128'd0);
      end
    end

    // R3: dwords 0..2 only stage
    v = {pat(3), pat(2), pat(1), pat(0)};
    for (int d = 0; d < 3; d++) wr32(wa(0,1,d), v[d*32 +: 32]);
    rd32(wa(0,1,0), r);
    chk("R3 staged not visible dw0", {64'd0, r}, 128'd0);
    rd32(wa(0,1,1), r);
    chk("R3 staged not visible dw1", {64'd0, r}, 128'd0);
    // R4: dword 3 commits all
    wr32(wa(0,1,3), v[127:96]);
    wm[1] = v;
    wide_check("R4 commit on dword3", 0, 1);
    chk("R4 no error", {127'd0, err_flag}, 128'd0);

    // R2 R4: sweep all pages and tables, dword and qword pieces
    for (int p = 0; p < PAGES; p++)
      for (int i = 0; i < NW; i++) begin
        v = {pat(p*64+i*4+3), pat(p*64+i*4+2), pat(p*64+i*4+1), pat(p*64+i*4)};
        wide_full(p, i, v, ((p + i) % 2) == 1);
        wm[p*NW+i] = v;
      end
    for (int p = 0; p < PAGES; p++)
      for (int i = 0; i < NW; i++) wide_check("R2 page/stride sweep", p, i);
    chk("R4 sweep no error", {127'd0, err_flag}, 128'd0);

    // R11: write gives no response
    wr32(wa(0,0,0), 32'h1);
    chk("R11 no rsp for write", {127'd0, last_rv}, 128'd0);
    wr32(wa(0,0,1), 32'h2);
    wr32(wa(0,0,2), 32'h3);
    wr32(wa(0,0,3), 32'h4);
    wm[0] = {32'h4, 32'h3, 32'h2, 32'h1};

    // R7: shadow snapshot
    rd32(wa(1,2,0), r);
    snap = wm[1*NW+2];
    chk("R7 dw0 live", {64'd0, r}, {96'd0, snap[31:0]});
    v = {pat(901), pat(902), pat(903), pat(904)};
    wide_full(1, 2, v, 1'b0);
    wm[1*NW+2] = v;
    rd32(wa(1,2,1), r);
    chk("R7 dw1 from shadow", {64'd0, r}, {96'd0, snap[63:32]});
    rd32(wa(1,2,3), r);
    chk("R7 dw3 from shadow", {64'd0, r}, {96'd0, snap[127:96]});
    rd64(wa(1,2,2), r);
    chk("R7 upper qword from shadow", {64'd0, r}, {64'd0, snap[127:64]});
    rd32(wa(1,2,0), r);
    chk("R7 new snapshot dw0", {64'd0, r}, {96'd0, v[31:0]});
    rd32(wa(1,2,2), r);
    chk("R7 new snapshot dw2", {64'd0, r}, {96'd0, v[95:64]});

    // R8: doorbells, alone and inside a wide collection
    for (int p = 0; p < PAGES; p++)
      for (int k = 0; k < 3; k++) begin
        wr32(p*PG + DBB + k*16, pat(500 + p*3 + k));
        dm[p*3+k] = pat(500 + p*3 + k);
      end
    for (int p = 0; p < PAGES; p++)
      for (int k = 0; k < 3; k++) begin
        rd32(p*PG + DBB + k*16, r);
        chk("R8 doorbell immediate", {64'd0, r}, {96'd0, dm[p*3+k]});
      end
    v = {pat(71), pat(72), pat(73), pat(74)};
    wr32(wa(1,0,0), v[31:0]);
    wr32(wa(1,0,1), v[63:32]);
    wr32(PG + DBB + 16, 32'hD00D_BE11);
    dm[4] = 32'hD00D_BE11;
    rd32(PG + DBB + 16, r);
    chk("R8 doorbell mid-collection", {64'd0, r}, {96'd0, dm[4]});
    wr32(wa(1,0,2), v[95:64]);
    wr32(wa(1,0,3), v[127:96]);
    wm[1*NW+0] = v;
    wide_check("R8 collection survives doorbell", 1, 0);
    chk("R8 no error", {127'd0, err_flag}, 128'd0);

    // R5: dword3 with nothing staged
    wr32(wa(0,2,3), 32'hBAD0_0003);
    chk("R5 lone dword3 error", {127'd0, err_flag}, 128'd1);
    wide_check("R5 lone dword3 dropped", 0, 2);
    // R13: sticky across good traffic, cleared by err_clr
    wide_full(0, 3, {pat(11), pat(12), pat(13), pat(14)}, 1'b1);
    wm[3] = {pat(11), pat(12), pat(13), pat(14)};
    chk("R13 error sticky", {127'd0, err_flag}, 128'd1);
    clear_err();
    chk("R13 error cleared", {127'd0, err_flag}, 128'd0);
    // R5: skipped dword2
    wr32(wa(0,2,0), 32'h1111_0000);
    wr32(wa(0,2,1), 32'h1111_0001);
    wr32(wa(0,2,3), 32'h1111_0003);
    chk("R5 missing dword2 error", {127'd0, err_flag}, 128'd1);
    wide_check("R5 missing dword2 dropped", 0, 2);
    clear_err();
    // R5: a second dword3 after a commit
    wr32(wa(0,3,3), 32'h2222_0003);
    chk("R5 repeat dword3 error", {127'd0, err_flag}, 128'd1);
    wide_check("R5 repeat dword3 dropped", 0, 3);
    clear_err();

    // R6: pieces to a different register
    wr32(wa(1,1,0), 32'h3333_0000);
    wr32(wa(1,3,1), 32'h3333_0001);
    chk("R6 base mismatch error", {127'd0, err_flag}, 128'd1);
    wr32(wa(1,3,2), 32'h3333_0002);
    wr32(wa(1,3,3), 32'h3333_0003);
    wide_check("R6 other register untouched", 1, 3);
    wide_check("R6 staged register untouched", 1, 1);
    clear_err();

    // R9: SRAM sweep, split and whole
    rd64(SRB, r);
    chk("R9 sram before write", {64'd0, r}, 128'd0);
    wr32(SRB, 32'h5A5A_0001);
    rd64(SRB, r);
    chk("R9 low dword only staged", {64'd0, r}, 128'd0);
    wr32(SRB + 4, 32'h5A5A_0002);
    sm[0] = {32'h5A5A_0002, 32'h5A5A_0001};
    for (int p = 0; p < PAGES; p++)
      for (int j = 0; j < SD; j++) begin
        if (p == 0 && j == 0) continue;
        if (j % 2 == 0) begin
          wr32(p*PG + SRB + j*8,     pat(300 + p*SD + j));
          wr32(p*PG + SRB + j*8 + 4, pat(400 + p*SD + j));
        end else begin
          wr64(p*PG + SRB + j*8, {pat(400 + p*SD + j), pat(300 + p*SD + j)});
        end
        sm[p*SD+j] = {pat(400 + p*SD + j), pat(300 + p*SD + j)};
      end
    for (int p = 0; p < PAGES; p++)
      for (int j = 0; j < SD; j++) begin
        rd64(p*PG + SRB + j*8, r);
        chk("R9 sram entry", {64'd0, r}, {64'd0, sm[p*SD+j]});
        rd32(p*PG + SRB + j*8 + 4, r);
        chk("R9 sram high dword", {64'd0, r}, {96'd0, sm[p*SD+j][63:32]});
      end
    chk("R9 sweep no error", {127'd0, err_flag}, 128'd0);
    wr32(PG + SRB + 3*8 + 4, 32'hDEAD_0004);
    chk("R9 lone high dword error", {127'd0, err_flag}, 128'd1);
    rd64(PG + SRB + 3*8, r);
    chk("R9 lone high dword dropped", {64'd0, r}, {64'd0, sm[SD+3]});
    clear_err();

    // R10: byte strobes
    v = wm[1*NW+1];
    wr32(wa(1,1,0), 32'hAABB_CCDD, 4'b0011);
    wr32(wa(1,1,1), 32'h1122_3344, 4'b1111);
    wr32(wa(1,1,2), 32'h5566_7788, 4'b0000);
    wr32(wa(1,1,3), 32'h99AA_BBCC, 4'b1000);
    wm[1*NW+1] = {mrg(v[127:96], 32'h99AA_BBCC, 4'b1000), v[95:64],
                  32'h1122_3344, mrg(v[31:0], 32'hAABB_CCDD, 4'b0011)};
    wide_check("R10 wide strobes", 1, 1);
    wr32(DBB + 32, 32'hF0E1_D2C3, 4'b0101);
    dm[2] = mrg(dm[2], 32'hF0E1_D2C3, 4'b0101);
    rd32(DBB + 32, r);
    chk("R10 doorbell strobes", {64'd0, r}, {96'd0, dm[2]});
    wr64(PG + SRB + 5*8, 64'h0123_4567_89AB_CDEF, 8'hF0);
    sm[SD+5] = {32'h0123_4567, sm[SD+5][31:0]};
    rd64(PG + SRB + 5*8, r);
    chk("R10 sram strobes", {64'd0, r}, {64'd0, sm[SD+5]});

    // R11: response and narrow read
    rd32(wa(0,1,0), r);
    chk("R11 rsp_valid on read", {127'd0, last_rv}, 128'd1);
    chk("R11 narrow read upper zero", {64'd0, r}, {96'd0, wm[1][31:0]});
    @(negedge clk);
    chk("R11 rsp_valid drops when idle", {127'd0, rsp_valid}, 128'd0);

    // R12: unmapped and misaligned
    wr32('h0700, 32'hFFFF_FFFF);
    rd32('h0700, r);
    chk("R12 unmapped read zero", {64'd0, r}, 128'd0);
    chk("R12 unmapped write no error", {127'd0, err_flag}, 128'd0);
    rd64(wa(0,1,1), r);
    chk("R12 misaligned qword zero", {64'd0, r}, 128'd0);
    wr64(DBB, 64'hFFFF_FFFF_FFFF_FFFF);
    rd32(DBB, r);
    chk("R12 qword to doorbell ignored", {64'd0, r}, {96'd0, dm[0]});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule